// File: doc/BRIEF.md
# Scaled System Counter

This block keeps a 64-bit physical time count that only moves upward. It is advanced by a counter tick strobe. On each accepted tick it adds either exactly one, or a programmable unsigned fixed-point step with an 8-bit integer part and a 24-bit fraction. The block holds two step registers, one for each of two possible clock sources, and a 2-bit source-select input picks which register applies. Software can preload each register once, and a later change of clock source then needs no reprogramming.

A 24-bit fraction accumulator sits below the visible count. Fractional steps therefore build up exactly, and their carries reach the integer count when they overflow. The count can be stopped in three ways: the run enable is low, the debug-halt input is high while halting on debug is allowed, or the source select holds an invalid code. A 64-bit load port overwrites the count at any time and wins over a same-cycle increment.

Top module: `sysctr_scaled`

## Requirements
- R1: During reset and straight after it, the count is 0, the fraction is 0, step register 0 holds 0x0100_0000 (1.0) and step register 1 holds 0x0200_0000 (2.0).
- R2: With scaling off (`scale_en_i`=0), each accepted tick raises the count by exactly 1 and leaves the fraction unchanged.
- R3: With scaling on, each accepted tick adds the selected step to the {count, fraction} pair. Bits 31:24 of the step are the integer part and bits 23:0 are the fraction. A carry out of the fraction raises the count by one more.
- R4: Select code 1 on `clk_sel_i` uses step register 0, and code 2 uses step register 1.
- R5: Select codes 0 and 3 are invalid, and a tick under either code changes nothing.
- R6: While `run_en_i` is 0 the count holds its value.
- R7: `halted_o` is 1 exactly when `halt_dbg_en_i` and `dbg_halt_i` are both 1. While it is 1 the count holds. `dbg_halt_i` alone has no effect.
- R8: A high `load_i` sets the count to `load_val_i` and clears the fraction on the next edge. This happens whatever the enable, halt, select or tick state, and overrides any increment.
- R9: A write strobe `step_we_i` stores `step_wdata_i` into register `step_widx_i` (0 or 1). A tick on the same edge still uses the old value.
- R10: Without a tick the count does not change.
- R11: The count wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counter tick strobe |
| run_en_i | input | 1 | Counter enable |
| scale_en_i | input | 1 | Use the selected step instead of +1 |
| halt_dbg_en_i | input | 1 | Allow debug halt to stop the count |
| dbg_halt_i | input | 1 | Debug halt request |
| clk_sel_i | input | 2 | Clock source code: 1 = source 0, 2 = source 1, 0/3 invalid |
| step_we_i | input | 1 | Step register write strobe |
| step_widx_i | input | 1 | Step register index for a write |
| step_wdata_i | input | 32 | Step value, 8.24 fixed point |
| load_i | input | 1 | Load strobe |
| load_val_i | input | 64 | Value to load |
| count_o | output | 64 | Current count |
| halted_o | output | 1 | Count is stopped by debug halt |

## Verification
A corrupted fraction accumulator does not show on `count_o` right away. It shows only when a later scaled tick carries, or fails to carry, one tick away from the expected point. For this reason the stimulus includes runs of fractional steps long enough to cross several carries. A wrong step register or a wrong select decode shows on the very next scaled tick as a wrong increment. A gating error shows within one cycle as a count that moves when it should hold, or holds when it should move.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
  typedef enum logic [1:0] {
    SEL_BAD_LO = 2'd0,
    SEL_SRC0   = 2'd1,
    SEL_SRC1   = 2'd2,
    SEL_BAD_HI = 2'd3
  } clk_sel_e;

  // Valid source codes are only 1 and 2 (R5)
  function automatic logic sel_is_valid(input logic [1:0] code);
    return (code == SEL_SRC0) || (code == SEL_SRC1);
  endfunction
endpackage

// File: rtl/sysctr_step_bank.sv
module sysctr_step_bank
  import sysctr_pkg::*;
#(
  parameter int          STEP_W = 32,
  parameter int          N_SRC  = 2,
  parameter logic [31:0] RST0   = 32'h0100_0000,
  parameter logic [31:0] RST1   = 32'h0200_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              widx_i,
  input  logic [STEP_W-1:0] wdata_i,
  input  logic [1:0]        sel_i,
  output logic [STEP_W-1:0] step_o,
  output logic              sel_ok_o
);
  logic [STEP_W-1:0] step_q [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_reg
    localparam logic [STEP_W-1:0] RST_V = (g == 0) ? RST0[STEP_W-1:0] : RST1[STEP_W-1:0];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 step_q[g] <= RST_V;
      else if (we_i && (int'(widx_i) == g))       step_q[g] <= wdata_i;
    end
  end

  clk_sel_e sel;
  assign sel      = clk_sel_e'(sel_i);
  assign sel_ok_o = sel_is_valid(sel_i);

  always_comb begin
    unique case (sel)
      SEL_SRC1: step_o = step_q[1];
      SEL_SRC0: step_o = step_q[0];
      default:  step_o = '0;
    endcase
  end
endmodule

// File: rtl/sysctr_gate.sv
module sysctr_gate (
  input  logic tick_i,
  input  logic run_en_i,
  input  logic halt_dbg_en_i,
  input  logic dbg_halt_i,
  input  logic sel_ok_i,
  output logic halted_o,
  output logic advance_o
);
  assign halted_o  = halt_dbg_en_i && dbg_halt_i;
  assign advance_o = tick_i && run_en_i && !halted_o && sel_ok_i;
endmodule

// File: rtl/sysctr_accum.sv
module sysctr_accum #(
  parameter int CNT_W  = 64,
  parameter int FRAC_W = 24,
  parameter int INT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [CNT_W-1:0]        load_val_i,
  input  logic                    advance_i,
  input  logic                    scale_en_i,
  input  logic [INT_W+FRAC_W-1:0] step_i,
  output logic [CNT_W-1:0]        count_o
);
  localparam int ACC_W  = CNT_W + FRAC_W;
  localparam int STEP_W = INT_W + FRAC_W;
  localparam logic [STEP_W-1:0] UNIT = STEP_W'(1) << FRAC_W;

  // {count, fraction}; the fraction carry flows into the count by the add
  logic [ACC_W-1:0]  acc_q;
  logic [STEP_W-1:0] inc;

  function automatic logic [ACC_W-1:0] acc_add(input logic [ACC_W-1:0] a,
                                               input logic [STEP_W-1:0] s);
    return a + {{(ACC_W-STEP_W){1'b0}}, s};
  endfunction

  assign inc = scale_en_i ? step_i : UNIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (load_i)    acc_q <= {load_val_i, {FRAC_W{1'b0}}};
    else if (advance_i) acc_q <= acc_add(acc_q, inc);
  end

  assign count_o = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/sysctr_scaled.sv
module sysctr_scaled #(
  parameter int          CNT_W  = 64,
  parameter int          FRAC_W = 24,
  parameter int          INT_W  = 8,
  parameter logic [31:0] RST0   = 32'h0100_0000,
  parameter logic [31:0] RST1   = 32'h0200_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic                    run_en_i,
  input  logic                    scale_en_i,
  input  logic                    halt_dbg_en_i,
  input  logic                    dbg_halt_i,
  input  logic [1:0]              clk_sel_i,
  input  logic                    step_we_i,
  input  logic                    step_widx_i,
  input  logic [INT_W+FRAC_W-1:0] step_wdata_i,
  input  logic                    load_i,
  input  logic [CNT_W-1:0]        load_val_i,
  output logic [CNT_W-1:0]        count_o,
  output logic                    halted_o
);
  localparam int STEP_W = INT_W + FRAC_W;

  logic [STEP_W-1:0] step_w;
  logic              sel_ok_w;
  logic              advance_w;
  logic              halted_w;

  sysctr_step_bank #(.STEP_W(STEP_W), .N_SRC(2), .RST0(RST0), .RST1(RST1)) u_bank (
    .clk(clk), .rst_n(rst_n), .we_i(step_we_i), .widx_i(step_widx_i),
    .wdata_i(step_wdata_i), .sel_i(clk_sel_i), .step_o(step_w), .sel_ok_o(sel_ok_w)
  );

  sysctr_gate u_gate (
    .tick_i(tick_i), .run_en_i(run_en_i), .halt_dbg_en_i(halt_dbg_en_i),
    .dbg_halt_i(dbg_halt_i), .sel_ok_i(sel_ok_w), .halted_o(halted_w),
    .advance_o(advance_w)
  );

  sysctr_accum #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(load_val_i),
    .advance_i(advance_w), .scale_en_i(scale_en_i), .step_i(step_w), .count_o(count_o)
  );

  assign halted_o = halted_w;
endmodule

// File: rtl/sysctr_scaled_chk.sv
module sysctr_scaled_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             run_en_i,
  input logic             scale_en_i,
  input logic [1:0]       clk_sel_i,
  input logic             load_i,
  input logic [CNT_W-1:0] load_val_i,
  input logic [CNT_W-1:0] count_o,
  input logic             halted_o,
  input logic             advance_w
);
  localparam logic [CNT_W-1:0] NEAR_TOP = {8'hFF, {(CNT_W-8){1'b0}}};

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> count_o == '0);

  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && run_en_i && !halted_o && !scale_en_i && !load_i &&
     (clk_sel_i == 2'd1 || clk_sel_i == 2'd2)) |=> count_o == $past(count_o) + 1'b1);

  assert_bad_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && (clk_sel_i == 2'd0 || clk_sel_i == 2'd3)) |=> $stable(count_o));

  assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !run_en_i) |=> $stable(count_o));

  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && halted_o) |=> $stable(count_o));

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> count_o == $past(load_val_i));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !advance_w) |=> $stable(count_o));

  assert_up_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && count_o < NEAR_TOP) |=> count_o >= $past(count_o));
endmodule

bind sysctr_scaled sysctr_scaled_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_en_i(run_en_i),
  .scale_en_i(scale_en_i), .clk_sel_i(clk_sel_i), .load_i(load_i),
  .load_val_i(load_val_i), .count_o(count_o), .halted_o(halted_o),
  .advance_w(advance_w)
);

// File: tb/sysctr_scaled_bench.sv
module sysctr_scaled_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 0, run_en_i = 0, scale_en_i = 0, halt_dbg_en_i = 0, dbg_halt_i = 0;
  logic [1:0]  clk_sel_i = 0;
  logic        step_we_i = 0, step_widx_i = 0;
  logic [31:0] step_wdata_i = 0;
  logic        load_i = 0;
  logic [63:0] load_val_i = 0;
  logic [63:0] count_o;
  logic        halted_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [63:0] m_cnt = 0;
  logic [23:0] m_frac = 0;
  logic [31:0] m_s0 = 32'h0100_0000;
  logic [31:0] m_s1 = 32'h0200_0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctr_scaled u_sysctr_scaled (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_en_i(run_en_i),
    .scale_en_i(scale_en_i), .halt_dbg_en_i(halt_dbg_en_i), .dbg_halt_i(dbg_halt_i),
    .clk_sel_i(clk_sel_i), .step_we_i(step_we_i), .step_widx_i(step_widx_i),
    .step_wdata_i(step_wdata_i), .load_i(load_i), .load_val_i(load_val_i),
    .count_o(count_o), .halted_o(halted_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Requirement-level next state: integer and fraction kept apart, carry explicit
  task automatic model_edge();
    logic        stop;
    logic [31:0] s;
    logic [24:0] fsum;
    stop = halt_dbg_en_i & dbg_halt_i;
    s = (clk_sel_i == 2'd1) ? m_s0 : m_s1;
    if (load_i) begin
      m_cnt = load_val_i; m_frac = 0;
    end else if (tick_i && run_en_i && !stop && (clk_sel_i == 2'd1 || clk_sel_i == 2'd2)) begin
      if (!scale_en_i) m_cnt = m_cnt + 64'd1;
      else begin
        fsum   = {1'b0, m_frac} + {1'b0, s[23:0]};
        m_frac = fsum[23:0];
        m_cnt  = m_cnt + {56'd0, s[31:24]} + {63'd0, fsum[24]};
      end
    end
    if (step_we_i) begin
      if (step_widx_i) m_s1 = step_wdata_i; else m_s0 = step_wdata_i;
    end
  endtask

  function automatic string auto_tag();
    if (load_i) return "R8";
    if (step_we_i) return "R9";
    if (!tick_i) return "R10";
    if (!run_en_i) return "R6";
    if (halt_dbg_en_i && dbg_halt_i) return "R7";
    if (clk_sel_i == 2'd0 || clk_sel_i == 2'd3) return "R5";
    if (scale_en_i) return (m_frac != 0) ? "R3" : "R4";
    return "R2";
  endfunction

  task automatic step(input logic ld, input logic [63:0] lv, input logic tk, input logic rn,
                      input logic se, input logic he, input logic dh, input logic [1:0] sl,
                      input logic we, input logic wi, input logic [31:0] wd, input string tag);
    string t;
    @(negedge clk);
    load_i = ld; load_val_i = lv; tick_i = tk; run_en_i = rn; scale_en_i = se;
    halt_dbg_en_i = he; dbg_halt_i = dh; clk_sel_i = sl;
    step_we_i = we; step_widx_i = wi; step_wdata_i = wd;
    #1;
    chk("R7 halted", {63'd0, halted_o}, {63'd0, he & dh});
    t = (tag == "") ? auto_tag() : tag;
    @(posedge clk);
    model_edge();
    #1;
    chk(t, count_o, m_cnt);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 count in reset", count_o, 64'd0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 count after reset", count_o, 64'd0);

    // reset step values: source 0 adds 1, source 1 adds 2
    step(0, 0, 1, 1, 1, 0, 0, 2'd1, 0, 0, 0, "R1");
    step(0, 0, 1, 1, 1, 0, 0, 2'd2, 0, 0, 0, "R1");
    // unscaled on both sources
    repeat (3) step(0, 0, 1, 1, 0, 0, 0, 2'd1, 0, 0, 0, "R2");
    step(0, 0, 1, 1, 0, 0, 0, 2'd2, 0, 0, 0, "R2");
    // program 0.5 into source 0, no tick
    step(0, 0, 0, 1, 1, 0, 0, 2'd1, 1, 0, 32'h0080_0000, "R9");
    repeat (3) step(0, 0, 1, 1, 1, 0, 0, 2'd1, 0, 0, 0, "R3");
    // 3.25 into source 1, four ticks cross a carry
    step(0, 0, 0, 1, 1, 0, 0, 2'd2, 1, 1, 32'h0340_0000, "R9");
    repeat (4) step(0, 0, 1, 1, 1, 0, 0, 2'd2, 0, 0, 0, "R4");
    // invalid codes
    step(0, 0, 1, 1, 1, 0, 0, 2'd0, 0, 0, 0, "R5");
    step(0, 0, 1, 1, 0, 0, 0, 2'd3, 0, 0, 0, "R5");
    // disabled
    step(0, 0, 1, 0, 0, 0, 0, 2'd1, 0, 0, 0, "R6");
    // debug halt without and with permission
    step(0, 0, 1, 1, 0, 0, 1, 2'd1, 0, 0, 0, "R7");
    step(0, 0, 1, 1, 0, 1, 1, 2'd1, 0, 0, 0, "R7");
    // load overrides increment, works while disabled/halted
    step(1, 64'h1234_5678_9ABC_DEF0, 1, 1, 1, 0, 0, 2'd1, 0, 0, 0, "R8");
    step(1, 64'h0000_0000_0000_0042, 1, 0, 1, 1, 1, 2'd0, 0, 0, 0, "R8");
    // write on the same edge as a scaled tick uses the old step
    step(0, 0, 1, 1, 1, 0, 0, 2'd1, 1, 0, 32'h0500_0000, "R9");
    step(0, 0, 1, 1, 1, 0, 0, 2'd1, 0, 0, 0, "R9");
    // wrap
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, 0, 0, 2'd1, 0, 0, 0, "R8");
    step(0, 0, 1, 1, 0, 0, 0, 2'd1, 0, 0, 0, "R11");
    step(1, 64'hFFFF_FFFF_FFFF_FFFE, 0, 1, 0, 0, 0, 2'd1, 0, 0, 0, "R8");
    step(0, 0, 1, 1, 1, 0, 0, 2'd1, 0, 0, 0, "R11");

    for (int i = 0; i < 4000; i++) begin
      logic ld, we;
      ld = ($urandom % 20) == 0;
      we = ($urandom % 10) == 0;
      step(ld, {$urandom, $urandom} >> ($urandom % 8), ($urandom % 10) < 7,
           ($urandom % 20) != 0, $urandom % 2, $urandom % 2, ($urandom % 5) == 0,
           2'($urandom), we, $urandom % 2, $urandom, "");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule